// File: doc/BRIEF.md
# Masked Interrupt Factor Controller

This block collects interrupt causes for a small 4-bit microcontroller core. Three timer event pulses and four input-pin event pulses arrive from outside. Each timer pulse sets its own latched factor flag. The four pins share a single factor flag, and a pin's pulse sets that flag only when the pin's own mask bit is set. Software reaches the mask bits and the flags through a nibble-wide register bus at four fixed addresses. Reading a flag register returns the flags and then clears them.

The controller drives one request line. The line is high when any flag is set and that flag's mask is enabled. While the entry sequencer is idle, it accepts a pending request. It then runs an entry of exactly twelve cycles. It first writes the next program counter, one nibble per cycle, to stack RAM. In the last cycle it loads the program counter with a vector address in page 1, between 01H and 07H. The vector encodes which groups of sources were pending when the request was accepted.

Top module: `irq_factor_ctrl`

## Requirements
- R1: After reset, every mask bit and every flag is 0. All four mapped registers read 0, `irq_req` is 0, and the sequencer is idle (`busy`, `stk_we` and `pc_ld` are all 0).
- R2: The timer masks are read/write at address 0xEB, with bit n enabling `tmr_evt[n]` (n = 0..2). The pin masks are read/write at address 0xE8, with bit n belonging to `pin_evt[n]`. Unused bits read 0 and ignore writes. Any unmapped address reads 0.
- R3: A pulse on `tmr_evt[n]` sets timer flag n whatever its mask holds. The timer flags read at address 0xEF in bits 2..0.
- R4: The shared pin flag reads at address 0xED bit 0. A pin pulse sets it only if that pin's mask bit is 1.
- R5: A read of 0xEF or 0xED returns the flags and clears them at the next edge. An event in the same cycle as the read leaves its flag set. Writes to the flag addresses have no effect.
- R6: `irq_req` is the OR of (timer flag n AND timer mask n) over all n, together with (pin flag AND any pin mask bit).
- R7: The vector is {enabled timer flag 2, enabled timer flag 1 OR enabled timer flag 0, enabled pin flag}, captured when the request is accepted. When `pc_ld` is high, `pc_ld_val` = {4'h1, 5'b0, vector}.
- R8: An accepted entry holds `busy` for exactly 12 cycles. In cycles 0, 1 and 2, `stk_we` is high, `stk_idx` is 0, 1 and 2, and `stk_wdata` is PC bits [3:0], [7:4] and [11:8]. `pc_ld` is high only in cycle 11.
- R9: A request is accepted at the clock edge where it is seen while idle. No new request is taken, and the captured vector does not change, while an entry runs. `busy` is low for at least one cycle between two entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the flags it reads) |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data, combinational from `reg_addr` |
| tmr_evt | input | 3 | Timer event pulses |
| pin_evt | input | 4 | Input-pin event pulses |
| pc_in | input | 12 | Address of the next instruction |
| irq_req | output | 1 | Interrupt request to the CPU |
| busy | output | 1 | Entry sequence running |
| stk_we | output | 1 | Stack RAM write strobe |
| stk_idx | output | 2 | Nibble index of the stack write |
| stk_wdata | output | 4 | PC nibble being saved |
| pc_ld | output | 1 | Program counter load strobe |
| pc_ld_val | output | 12 | Vector address to load |

## Verification
The bench sweeps every timer mask against every timer event pattern, and every pin mask against every pin event pattern. A design that let a masked pin set the shared flag, or that gated timer flags with their masks, fails there. It also fails there if it left a flag set after reading it. A read is made in the same cycle as an event to catch a read-clear that wipes the new event. Entries are run for all seven vector codes, with extra events injected mid-entry. A sequencer that re-captured the vector, saved nibbles in the wrong order, or was off by one cycle in the twelve-cycle count would load a wrong address or strobe at the wrong time.

// File: rtl/irq_factor_pkg.sv
`timescale 1ns/1ps
package irq_factor_pkg;
    localparam int NIB_W     = 4;
    localparam int TMR_NUM   = 3;
    localparam int PIN_NUM   = 4;
    localparam int PCW       = 12;
    localparam int ENTRY_LEN = 12;
    localparam int ADDR_W    = 8;
    localparam int VEC_W     = 3;

    localparam logic [ADDR_W-1:0] ADR_PIN_MASK = 8'hE8;
    localparam logic [ADDR_W-1:0] ADR_TMR_MASK = 8'hEB;
    localparam logic [ADDR_W-1:0] ADR_PIN_FLAG = 8'hED;
    localparam logic [ADDR_W-1:0] ADR_TMR_FLAG = 8'hEF;
    localparam logic [3:0]        VEC_PAGE     = 4'h1;

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;

    // decoded bus access for one cycle
    typedef struct packed {
        logic wr_tmask;
        logic wr_pmask;
        logic rd_tflag;
        logic rd_pflag;
    } bus_dec_t;

    function automatic bus_dec_t decode_bus(input logic [ADDR_W-1:0] a,
                                            input logic wr, input logic rd);
        bus_dec_t d;
        d.wr_tmask = wr && (a == ADR_TMR_MASK);
        d.wr_pmask = wr && (a == ADR_PIN_MASK);
        d.rd_tflag = rd && (a == ADR_TMR_FLAG);
        d.rd_pflag = rd && (a == ADR_PIN_FLAG);
        return d;
    endfunction
endpackage

// File: rtl/irq_reg_bank.sv
`timescale 1ns/1ps
module irq_reg_bank
    import irq_factor_pkg::*;
#(
    parameter int TMR_N = TMR_NUM,
    parameter int PIN_N = PIN_NUM,
    parameter int NIB   = NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [NIB-1:0]    wdata,
    output logic [NIB-1:0]    rdata,
    input  logic [TMR_N-1:0]  tmr_evt,
    input  logic [PIN_N-1:0]  pin_evt,
    output logic [TMR_N-1:0]  tmask,
    output logic [PIN_N-1:0]  pmask,
    output logic [TMR_N-1:0]  tflag,
    output logic              pflag
);
    bus_dec_t dec;
    logic     pin_hit;

    assign dec     = decode_bus(addr, wr, rd);
    assign pin_hit = |(pin_evt & pmask);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmask <= '0;
            pmask <= '0;
            tflag <= '0;
            pflag <= 1'b0;
        end else begin
            if (dec.wr_tmask) tmask <= wdata[TMR_N-1:0];
            if (dec.wr_pmask) pmask <= wdata[PIN_N-1:0];
            // read-clear first, then this cycle's events win
            tflag <= (dec.rd_tflag ? '0 : tflag) | tmr_evt;
            pflag <= (dec.rd_pflag ? 1'b0 : pflag) | pin_hit;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_TMR_MASK: rdata = NIB'(tmask);
            ADR_PIN_MASK: rdata = NIB'(pmask);
            ADR_TMR_FLAG: rdata = NIB'(tflag);
            ADR_PIN_FLAG: rdata = NIB'(pflag);
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_req_gen.sv
`timescale 1ns/1ps
module irq_req_gen
    import irq_factor_pkg::*;
#(
    parameter int TMR_N = TMR_NUM,
    parameter int PIN_N = PIN_NUM
) (
    input  logic [TMR_N-1:0] tmask,
    input  logic [PIN_N-1:0] pmask,
    input  logic [TMR_N-1:0] tflag,
    input  logic             pflag,
    output logic             irq_req,
    output logic [VEC_W-1:0] vec
);
    logic [TMR_N-1:0] tpend;
    logic             ppend;

    assign tpend   = tflag & tmask;
    assign ppend   = pflag & (|pmask);
    assign irq_req = (|tpend) | ppend;
    // group code: slowest timer high, other timers middle, pins low
    assign vec     = {tpend[TMR_N-1], |tpend[TMR_N-2:0], ppend};
endmodule

// File: rtl/irq_entry_seq.sv
`timescale 1ns/1ps
module irq_entry_seq
    import irq_factor_pkg::*;
#(
    parameter int PC_W      = PCW,
    parameter int NIB       = NIB_W,
    parameter int ENTRY_CYC = ENTRY_LEN,
    localparam int NIBS     = PC_W / NIB,
    localparam int IW       = $clog2(NIBS),
    localparam int CW       = $clog2(ENTRY_CYC),
    localparam int STEP_W   = PC_W - 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [VEC_W-1:0] vec,
    input  logic [PC_W-1:0]  pc_in,
    output logic             busy,
    output logic             stk_we,
    output logic [IW-1:0]    stk_idx,
    output logic [NIB-1:0]   stk_wdata,
    output logic             pc_ld,
    output logic [PC_W-1:0]  pc_ld_val
);
    seq_state_t       st;
    logic [CW-1:0]    cnt;
    logic [PC_W-1:0]  pc_q;
    logic [VEC_W-1:0] vec_q;
    logic [PC_W-1:0]  pc_sh;
    logic             last;

    assign last = (cnt == CW'(ENTRY_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SEQ_IDLE;
            cnt   <= '0;
            pc_q  <= '0;
            vec_q <= '0;
        end else begin
            case (st)
                SEQ_IDLE: if (req) begin
                    st    <= SEQ_RUN;
                    cnt   <= '0;
                    pc_q  <= pc_in;
                    vec_q <= vec;
                end
                SEQ_RUN: begin
                    if (last) st <= SEQ_IDLE;
                    else      cnt <= cnt + 1'b1;
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    assign busy      = (st == SEQ_RUN);
    assign stk_we    = busy && (cnt < CW'(NIBS));
    assign stk_idx   = IW'(cnt);
    assign pc_sh     = pc_q >> (NIB * 32'(cnt));
    assign stk_wdata = pc_sh[NIB-1:0];
    assign pc_ld     = busy && last;
    assign pc_ld_val = {VEC_PAGE, STEP_W'(vec_q)};
endmodule

// File: rtl/irq_factor_ctrl.sv
`timescale 1ns/1ps
module irq_factor_ctrl
    import irq_factor_pkg::*;
#(
    parameter int TMR_N     = TMR_NUM,
    parameter int PIN_N     = PIN_NUM,
    parameter int NIB       = NIB_W,
    parameter int PC_W      = PCW,
    parameter int ENTRY_CYC = ENTRY_LEN
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [NIB-1:0]               reg_wdata,
    output logic [NIB-1:0]               reg_rdata,
    input  logic [TMR_N-1:0]             tmr_evt,
    input  logic [PIN_N-1:0]             pin_evt,
    input  logic [PC_W-1:0]              pc_in,
    output logic                         irq_req,
    output logic                         busy,
    output logic                         stk_we,
    output logic [$clog2(PC_W/NIB)-1:0]  stk_idx,
    output logic [NIB-1:0]               stk_wdata,
    output logic                         pc_ld,
    output logic [PC_W-1:0]              pc_ld_val
);
    logic [TMR_N-1:0] tmask, tflag;
    logic [PIN_N-1:0] pmask;
    logic             pflag;
    logic [VEC_W-1:0] vec;

    irq_reg_bank #(.TMR_N(TMR_N), .PIN_N(PIN_N), .NIB(NIB)) u_regs (
        .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
        .wdata(reg_wdata), .rdata(reg_rdata), .tmr_evt(tmr_evt),
        .pin_evt(pin_evt), .tmask(tmask), .pmask(pmask),
        .tflag(tflag), .pflag(pflag)
    );

    irq_req_gen #(.TMR_N(TMR_N), .PIN_N(PIN_N)) u_req (
        .tmask(tmask), .pmask(pmask), .tflag(tflag), .pflag(pflag),
        .irq_req(irq_req), .vec(vec)
    );

    irq_entry_seq #(.PC_W(PC_W), .NIB(NIB), .ENTRY_CYC(ENTRY_CYC)) u_seq (
        .clk(clk), .rst(rst), .req(irq_req), .vec(vec), .pc_in(pc_in),
        .busy(busy), .stk_we(stk_we), .stk_idx(stk_idx),
        .stk_wdata(stk_wdata), .pc_ld(pc_ld), .pc_ld_val(pc_ld_val)
    );
endmodule

// File: rtl/irq_factor_chk.sv
`timescale 1ns/1ps
module irq_factor_chk
    import irq_factor_pkg::*;
#(
    parameter int PC_W      = PCW,
    parameter int NIB       = NIB_W,
    parameter int ENTRY_CYC = ENTRY_LEN
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NIB-1:0]    reg_rdata,
    input logic              irq_req,
    input logic              busy,
    input logic              stk_we,
    input logic              pc_ld,
    input logic [PC_W-1:0]   pc_ld_val
);
    logic [15:0] run_len;
    logic        mapped;

    assign mapped = (reg_addr == ADR_TMR_MASK) || (reg_addr == ADR_PIN_MASK) ||
                    (reg_addr == ADR_TMR_FLAG) || (reg_addr == ADR_PIN_FLAG);

    always_ff @(posedge clk) begin
        if (rst || !busy) run_len <= '0;
        else              run_len <= run_len + 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!busy && !irq_req)); // R1
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst) !mapped |-> reg_rdata == '0); // R2
    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (rst) (!busy && irq_req) |=> busy); // R9
    AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (rst) (busy && !pc_ld) |=> busy); // R9
    AST_LOAD_ENDS: assert property (@(posedge clk) disable iff (rst) pc_ld |=> !busy); // R8
    AST_STACK_IN_RUN: assert property (@(posedge clk) disable iff (rst) stk_we |-> (busy && !pc_ld)); // R8
    AST_ENTRY_LEN: assert property (@(posedge clk) disable iff (rst) pc_ld |-> (run_len == 16'(ENTRY_CYC - 1))); // R8
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        pc_ld |-> (pc_ld_val[PC_W-1:PC_W-4] == VEC_PAGE &&
                   pc_ld_val[PC_W-5:0] >= 1 && pc_ld_val[PC_W-5:0] <= 7)); // R7
endmodule

bind irq_factor_ctrl irq_factor_chk #(.PC_W(PC_W), .NIB(NIB), .ENTRY_CYC(ENTRY_CYC)) u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .busy(busy), .stk_we(stk_we),
    .pc_ld(pc_ld), .pc_ld_val(pc_ld_val)
);

// File: tb/tb_irq_factor_ctrl.sv
`timescale 1ns/1ps
module tb_irq_factor_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_wdata = '0;
    logic [3:0]  reg_rdata;
    logic [2:0]  tmr_evt = '0;
    logic [3:0]  pin_evt = '0;
    logic [11:0] pc_in = '0;
    logic        irq_req, busy, stk_we, pc_ld;
    logic [1:0]  stk_idx;
    logic [3:0]  stk_wdata;
    logic [11:0] pc_ld_val;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    irq_factor_ctrl dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_evt(tmr_evt),
        .pin_evt(pin_evt), .pc_in(pc_in), .irq_req(irq_req), .busy(busy),
        .stk_we(stk_we), .stk_idx(stk_idx), .stk_wdata(stk_wdata),
        .pc_ld(pc_ld), .pc_ld_val(pc_ld_val)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [3:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [3:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] te, input logic [3:0] pe);
        tmr_evt = te; pin_evt = pe;
        @(negedge clk);
        tmr_evt = '0; pin_evt = '0;
    endtask

    task automatic clear_all();
        logic [3:0] d;
        bus_wr(8'hEB, 4'h0);
        bus_wr(8'hE8, 4'h0);
        bus_rd(8'hEF, d);
        bus_rd(8'hED, d);
        while (busy) @(negedge clk);
    endtask

    // called at the negedge right after the events were latched
    task automatic run_entry(input logic [11:0] pc, input logic [2:0] vexp,
                             input logic [2:0] mid_t);
        check(irq_req == 1'b1 && busy == 1'b0, "R9 pending while idle", {irq_req, busy}, 2'b10);
        @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            check(busy == 1'b1, "R8 busy held", busy, 1);
            check(stk_we == (i < 3), "R8 stack strobe", stk_we, (i < 3));
            if (i < 3) begin
                check(stk_idx == 2'(i), "R8 stack index", stk_idx, i);
                check(stk_wdata == 4'((pc >> (4 * i)) & 12'hF), "R8 stack nibble",
                      stk_wdata, (pc >> (4 * i)) & 12'hF);
            end
            check(pc_ld == (i == 11), "R8 load strobe", pc_ld, (i == 11));
            if (i == 11)
                check(pc_ld_val == {4'h1, 5'b0, vexp}, "R7 vector address",
                      pc_ld_val, {4'h1, 5'b0, vexp});
            if (i == 4) tmr_evt = mid_t;
            @(negedge clk);
            tmr_evt = '0;
        end
        check(busy == 1'b0, "R9 idle gap after entry", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [3:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(irq_req == 0 && busy == 0 && stk_we == 0 && pc_ld == 0, "R1 outputs idle",
              {irq_req, busy, stk_we, pc_ld}, 0);
        bus_rd(8'hEB, d); check(d == 0, "R1 timer mask", d, 0);
        bus_rd(8'hE8, d); check(d == 0, "R1 pin mask", d, 0);
        bus_rd(8'hEF, d); check(d == 0, "R1 timer flags", d, 0);
        bus_rd(8'hED, d); check(d == 0, "R1 pin flag", d, 0);

        // R2 unused bits and unmapped addresses
        bus_wr(8'hEB, 4'hF); bus_rd(8'hEB, d); check(d == 4'h7, "R2 unused bit", d, 7);
        bus_wr(8'hE9, 4'hF); bus_rd(8'hE9, d); check(d == 0, "R2 unmapped", d, 0);
        clear_all();

        // R5 writes to flags ignored
        bus_wr(8'hEF, 4'h7); bus_wr(8'hED, 4'h1);
        bus_rd(8'hEF, d); check(d == 0, "R5 timer flag write ignored", d, 0);
        bus_rd(8'hED, d); check(d == 0, "R5 pin flag write ignored", d, 0);

        // R3 R5 R6 timer sweep
        for (int tm = 0; tm < 8; tm++) begin
            for (int ev = 0; ev < 8; ev++) begin
                bus_wr(8'hEB, 4'(tm));
                bus_rd(8'hEF, d);
                pulse(3'(ev), 4'h0);
                check(irq_req == ((ev & tm) != 0), "R6 timer request", irq_req, (ev & tm) != 0);
                bus_rd(8'hEF, d);
                check(d == 4'(ev), "R3 timer flags", d, ev);
                check(irq_req == 0, "R5 cleared after read", irq_req, 0);
                bus_rd(8'hEF, d);
                check(d == 0, "R5 second read", d, 0);
                bus_rd(8'hEB, d);
                check(d == 4'(tm), "R2 timer mask readback", d, tm);
            end
        end
        clear_all();

        // R4 R6 pin sweep
        for (int pm = 0; pm < 16; pm++) begin
            for (int ev = 0; ev < 16; ev++) begin
                bus_wr(8'hE8, 4'(pm));
                bus_rd(8'hED, d);
                pulse(3'b0, 4'(ev));
                check(irq_req == ((pm & ev) != 0), "R6 pin request", irq_req, (pm & ev) != 0);
                bus_rd(8'hED, d);
                check(d == 4'((pm & ev) != 0), "R4 pin flag", d, (pm & ev) != 0);
                bus_rd(8'hE8, d);
                check(d == 4'(pm), "R2 pin mask readback", d, pm);
            end
        end
        clear_all();

        // R6 pin flag stays but request drops when masks close
        bus_wr(8'hE8, 4'h1); pulse(3'b0, 4'h1); bus_wr(8'hE8, 4'h0);
        check(irq_req == 0, "R6 masked pending pin", irq_req, 0);
        bus_rd(8'hED, d); check(d == 1, "R4 flag kept while masked", d, 1);

        // R5 event in same cycle as read
        clear_all();
        reg_addr = 8'hEF; reg_rd = 1'b1; tmr_evt = 3'b010;
        #1 d = reg_rdata;
        check(d == 0, "R5 read returns old value", d, 0);
        @(negedge clk); reg_rd = 1'b0; tmr_evt = '0;
        bus_rd(8'hEF, d); check(d == 4'h2, "R5 same-cycle event kept", d, 2);

        // R7 R8 R9 entry for every vector code
        for (int v = 1; v < 8; v++) begin
            logic [2:0] te;
            clear_all();
            pc_in = 12'(v * 12'h2B7 + 12'h105);
            bus_wr(8'hEB, 4'h7); bus_wr(8'hE8, 4'hF);
            te = {v[2], v[1], 1'b0};
            pulse(te, {3'b0, v[0]});
            run_entry(pc_in, 3'(v), ~te);
        end
        // R7 lowest timer alone maps to the middle bit
        clear_all();
        pc_in = 12'hC3E;
        bus_wr(8'hEB, 4'h7);
        pulse(3'b001, 4'h0);
        run_entry(12'hC3E, 3'b010, 3'b100);

        // R1 reset mid-operation
        clear_all();
        bus_wr(8'hEB, 4'h5); bus_wr(8'hE8, 4'hA); pulse(3'b111, 4'hF);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check(irq_req == 0 && busy == 0, "R1 reset clears request", {irq_req, busy}, 0);
        bus_rd(8'hEB, d); check(d == 0, "R1 timer mask after reset", d, 0);
        bus_rd(8'hE8, d); check(d == 0, "R1 pin mask after reset", d, 0);
        bus_rd(8'hEF, d); check(d == 0, "R1 flags after reset", d, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule